// File: doc/BRIEF.md
# Frame Heap Free-List Allocator

This block hands out and takes back fixed-size activation frames kept in a word-addressed memory. Each size class owns a singly linked free list. The head word of class k sits at address 0x0200 (octal 1000) plus k. An allocate request names a class. The block walks the head word, then either pops a frame, follows a redirection to another class, or reports that the list is empty. A free request names a frame. The block reads the class index stored in the word just before the frame and pushes the frame onto that class list in last-in, first-out order.

The block talks to a single-port memory master interface that performs one access per cycle. Read data comes back registered, one cycle after the read is issued. It holds its value until the next read. A request is taken only while the block is idle. Every operation ends with a one-cycle `done` pulse that comes with its result.

The controller is one state machine:

- ST_IDLE waits for work.
- The allocate path runs ST_A_HEAD (read the head word), then ST_A_TAG (decode the tag), then ST_A_LINK (read the frame's link word), then ST_A_UPD (write the link into the head).
- The free path runs ST_F_CLS (read the class word), then ST_F_HEAD (read the head word), then ST_F_LINK (write the old head into the frame), then ST_F_UPD (write the frame into the head).

The transitions are:

- ST_IDLE goes to ST_A_HEAD on an allocate request, or to ST_F_CLS on a free request.
- ST_A_TAG goes to ST_A_LINK on tag 00.
- ST_A_TAG goes back to ST_A_HEAD on a redirect while hop budget remains.
- ST_A_TAG goes to ST_IDLE on tag 01, and also on a redirect once the budget is used up.
- Every other state steps to the next state on its path.
- ST_A_UPD and ST_F_UPD return to ST_IDLE.

Top module: `frame_pool_alloc`

## Requirements
- R1: After reset, `done`, `empty_trap`, `loop_err` and `mem_en` are low and `frame_out` is 0.
- R2: The head word of class k is read from and written to address 0x0200 + k.
- R3: An allocation whose head word has low bits 00 returns that head word on `frame_out`. It writes the frame's word 0 into the head, which is one memory write. `done` rises 5 cycles after the accepting edge. `frame_out` bits [1:0] are always 00.
- R4: A head word with bit 1 set redirects the allocation to class index head[CLASS_W+1:2]. Each redirect adds 2 cycles.
- R5: A head word with low bits 01 ends the allocation with `empty_trap` and `done` together, `frame_out` = 0 and no memory write. This happens 3 cycles after acceptance, plus 2 per redirect taken.
- R6: An allocation that meets a redirect after HOP_LIMIT (default 8) redirects already taken ends with `loop_err`, `frame_out` = 0 and no memory write. With the default limit this is 19 cycles after acceptance.
- R7: A free of frame P reads the class c from word P-1. It writes the old head of c into word P and then writes P into the head of c. That is two writes, with `done` 5 cycles after acceptance, so the next allocation from c returns P.
- R8: Requests are accepted only in ST_IDLE and are ignored while busy. When allocate and free are both requested in the same cycle, the allocate is taken and the free is dropped.
- R9: `done` is a one-cycle pulse, and `empty_trap` and `loop_err` are never high together.
- R10: `mem_we` is only high with `mem_en`, and no memory access is made in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocate request, taken when idle |
| alloc_class | input | CLASS_W | Size class to allocate from |
| free_req | input | 1 | Free request, taken when idle |
| free_ptr | input | 16 | Frame to return |
| done | output | 1 | One-cycle completion pulse |
| frame_out | output | 16 | Allocated frame, 0 for traps and frees |
| empty_trap | output | 1 | List-empty trap, with done |
| loop_err | output | 1 | Redirect chain too long, with done |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |

## Verification
Each result has a fixed due cycle, counted from the rising edge that accepts the request:

- A direct allocation or a free completes after 5 edges.
- An empty-list trap completes after 3 edges.
- Each redirect adds 2 edges, so the default loop error lands after 19 edges.

The bench counts edges from acceptance, sampling 1 ns after each edge. It compares the count at which `done` appears against the value held in each stimulus vector, and checks that `done` is low again one edge later. Memory writes are counted by the bench's own memory model over each operation. The list contents it relies on are read back through later allocations.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
    localparam int unsigned WORD_W = 16;
    localparam logic [WORD_W-1:0] HEAD_TABLE_BASE = 16'h0200;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_A_HEAD,
        ST_A_TAG,
        ST_A_LINK,
        ST_A_UPD,
        ST_F_CLS,
        ST_F_HEAD,
        ST_F_LINK,
        ST_F_UPD
    } fpa_state_e;
endpackage

// File: rtl/fpa_tag_decode.sv
module fpa_tag_decode #(
    parameter int unsigned CLASS_W = 8
) (
    input  logic [fpa_pkg::WORD_W-1:0] head_word,
    output logic                       is_frame,
    output logic                       is_empty,
    output logic                       is_redirect,
    output logic [CLASS_W-1:0]         next_class
);
    // Tag lives in the two low bits: 00 frame, 01 empty, 1x redirect
    always_comb begin
        is_frame    = (head_word[1:0] == 2'b00);
        is_empty    = (head_word[1:0] == 2'b01);
        is_redirect = head_word[1];
        next_class  = head_word[CLASS_W+1:2];
    end
endmodule

// File: rtl/fpa_hop_guard.sv
module fpa_hop_guard #(
    parameter int unsigned HOP_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic exhausted
);
    localparam int unsigned CNT_W = $clog2(HOP_LIMIT + 1);

    logic [CNT_W-1:0] hops_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            hops_q <= '0;
        end else if (step) begin
            hops_q <= hops_q + 1'b1;
        end
    end

    assign exhausted = (hops_q == CNT_W'(HOP_LIMIT));

    AST_HOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hops_q <= CNT_W'(HOP_LIMIT)); // R6
endmodule

// File: rtl/frame_pool_alloc.sv
module frame_pool_alloc #(
    parameter int unsigned CLASS_W   = 8,
    parameter int unsigned HOP_LIMIT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_req,
    input  logic [CLASS_W-1:0] alloc_class,
    input  logic               free_req,
    input  logic [15:0]        free_ptr,
    output logic               done,
    output logic [15:0]        frame_out,
    output logic               empty_trap,
    output logic               loop_err,
    output logic               mem_en,
    output logic               mem_we,
    output logic [15:0]        mem_addr,
    output logic [15:0]        mem_wdata,
    input  logic [15:0]        mem_rdata
);
    import fpa_pkg::*;

    localparam int unsigned PAD_W = WORD_W - CLASS_W;

    fpa_state_e           state_q, state_d;
    logic [CLASS_W-1:0]   cls_q;
    logic [WORD_W-1:0]    frame_q;
    logic                 tag_frame, tag_empty, tag_redir;
    logic [CLASS_W-1:0]   redir_class;
    logic                 hops_out;
    logic                 fin_ok, fin_free, fin_trap, fin_loop;

    fpa_tag_decode #(.CLASS_W(CLASS_W)) u_tag (
        .head_word   (mem_rdata),
        .is_frame    (tag_frame),
        .is_empty    (tag_empty),
        .is_redirect (tag_redir),
        .next_class  (redir_class)
    );

    fpa_hop_guard #(.HOP_LIMIT(HOP_LIMIT)) u_hops (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_IDLE),
        .step      (state_q == ST_A_TAG && tag_redir && !hops_out),
        .exhausted (hops_out)
    );

    function automatic logic [WORD_W-1:0] head_addr(input logic [CLASS_W-1:0] c);
        return HEAD_TABLE_BASE + {{PAD_W{1'b0}}, c};
    endfunction

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (alloc_req)     state_d = ST_A_HEAD;
                else if (free_req) state_d = ST_F_CLS;
            end
            ST_A_HEAD: state_d = ST_A_TAG;
            ST_A_TAG: begin
                if (tag_frame)      state_d = ST_A_LINK;
                else if (tag_empty) state_d = ST_IDLE;
                else if (hops_out)  state_d = ST_IDLE;
                else                state_d = ST_A_HEAD;
            end
            ST_A_LINK: state_d = ST_A_UPD;
            ST_A_UPD:  state_d = ST_IDLE;
            ST_F_CLS:  state_d = ST_F_HEAD;
            ST_F_HEAD: state_d = ST_F_LINK;
            ST_F_LINK: state_d = ST_F_UPD;
            ST_F_UPD:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Memory-side outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_A_HEAD: begin mem_en = 1'b1; mem_addr = head_addr(cls_q); end
            ST_A_LINK: begin mem_en = 1'b1; mem_addr = frame_q; end
            ST_A_UPD: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr = head_addr(cls_q); mem_wdata = mem_rdata;
            end
            ST_F_CLS:  begin mem_en = 1'b1; mem_addr = frame_q - 16'd1; end
            ST_F_HEAD: begin mem_en = 1'b1; mem_addr = head_addr(mem_rdata[CLASS_W-1:0]); end
            ST_F_LINK: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr = frame_q; mem_wdata = mem_rdata;
            end
            ST_F_UPD: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr = head_addr(cls_q); mem_wdata = frame_q;
            end
            default: ;
        endcase
    end

    // Working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q   <= '0;
            frame_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (alloc_req)     cls_q   <= alloc_class;
                    else if (free_req) frame_q <= free_ptr;
                end
                ST_A_TAG: begin
                    if (tag_frame)      frame_q <= mem_rdata;
                    else if (tag_redir) cls_q   <= redir_class;
                end
                ST_F_HEAD: cls_q <= mem_rdata[CLASS_W-1:0];
                default: ;
            endcase
        end
    end

    assign fin_ok   = (state_q == ST_A_UPD);
    assign fin_free = (state_q == ST_F_UPD);
    assign fin_trap = (state_q == ST_A_TAG) && tag_empty;
    assign fin_loop = (state_q == ST_A_TAG) && tag_redir && hops_out;

    // Result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            frame_out  <= '0;
            empty_trap <= 1'b0;
            loop_err   <= 1'b0;
        end else begin
            done       <= fin_ok || fin_free || fin_trap || fin_loop;
            empty_trap <= fin_trap;
            loop_err   <= fin_loop;
            if (fin_ok)                            frame_out <= frame_q;
            else if (fin_free || fin_trap || fin_loop) frame_out <= '0;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({empty_trap, loop_err})); // R9
    AST_TRAP_NOFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_trap || loop_err) |-> (done && frame_out == 16'd0)); // R5
    AST_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_out[1:0] == 2'b00); // R3
    AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !mem_en); // R10
    AST_HEAD_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_A_HEAD) |-> (mem_addr >= HEAD_TABLE_BASE)); // R2
endmodule

// File: tb/frame_pool_alloc_bench.sv
`timescale 1ns/1ps
module frame_pool_alloc_bench;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_req = 1'b0;
    logic [CW-1:0] alloc_class = '0;
    logic          free_req = 1'b0;
    logic [15:0]   free_ptr = '0;
    logic          done, empty_trap, loop_err, mem_en, mem_we;
    logic [15:0]   frame_out, mem_addr, mem_wdata;
    logic [15:0]   mem_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int wr_cnt   = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    frame_pool_alloc #(.CLASS_W(CW), .HOP_LIMIT(8)) u_frame_pool_alloc (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_class(alloc_class),
        .free_req(free_req), .free_ptr(free_ptr),
        .done(done), .frame_out(frame_out),
        .empty_trap(empty_trap), .loop_err(loop_err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model with a backdoor poke port
    logic [15:0] mem [1024];
    logic        poke_en = 1'b0;
    logic [15:0] poke_a = '0, poke_d = '0;

    always_ff @(posedge clk) begin
        if (poke_en) mem[poke_a[9:0]] <= poke_d;
        else if (mem_en && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[9:0]];
        if (mem_en && mem_we) wr_cnt <= wr_cnt + 1;
        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_a = a; poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    // op: 0 alloc, 1 free. kind: 0 ok, 1 empty trap, 2 loop error
    task automatic run_op(input int op, input logic [15:0] arg,
                          output int kind, output logic [15:0] frm,
                          output int lat, output int wrs);
        int w0;
        @(negedge clk);
        w0 = wr_cnt;
        if (op == 0) begin alloc_req = 1'b1; alloc_class = arg[CW-1:0]; end
        else         begin free_req = 1'b1;  free_ptr = arg; end
        lat = 0;
        kind = 0;
        frm = '0;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); #1;
            alloc_req = 1'b0; free_req = 1'b0;
            lat++;
            if (done) break;
        end
        kind = empty_trap ? 1 : (loop_err ? 2 : 0);
        frm  = frame_out;
        @(posedge clk); #1;
        check(!done, "R9", "done pulse width", done, 0);
        wrs = wr_cnt - w0;
    endtask

    function automatic string tag_of(input int op, input int kind, input int arg);
        if (op == 1)   return "R7";
        if (kind == 1) return "R5";
        if (kind == 2) return "R6";
        if (arg == 1 || arg == 4) return "R4";
        return "R3";
    endfunction

    // {op[1:0], arg[15:0], kind[1:0], frame[15:0], lat[7:0], writes[3:0]}
    localparam int NV = 12;
    localparam logic [47:0] VEC [NV] = '{
        {2'd0, 16'h0000, 2'd0, 16'h0010, 8'd5,  4'd1},
        {2'd0, 16'h0001, 2'd0, 16'h0020, 8'd7,  4'd1},
        {2'd0, 16'h0000, 2'd1, 16'h0000, 8'd3,  4'd0},
        {2'd0, 16'h0003, 2'd1, 16'h0000, 8'd7,  4'd0},
        {2'd0, 16'h0005, 2'd2, 16'h0000, 8'd19, 4'd0},
        {2'd1, 16'h0010, 2'd0, 16'h0000, 8'd5,  4'd2},
        {2'd1, 16'h0020, 2'd0, 16'h0000, 8'd5,  4'd2},
        {2'd0, 16'h0000, 2'd0, 16'h0020, 8'd5,  4'd1},
        {2'd1, 16'h0030, 2'd0, 16'h0000, 8'd5,  4'd2},
        {2'd0, 16'h0004, 2'd0, 16'h0030, 8'd7,  4'd1},
        {2'd0, 16'h0001, 2'd0, 16'h0010, 8'd7,  4'd1},
        {2'd0, 16'h0002, 2'd1, 16'h0000, 8'd3,  4'd0}
    };

    initial begin
        int kind, lat, wrs, dcount;
        logic [15:0] frm;
        // Heap image (R2: heads at 0x0200 + class)
        poke(16'h0200, 16'h0010);  // class 0 -> 0x10
        poke(16'h0010, 16'h0020);  // 0x10 -> 0x20
        poke(16'h0020, 16'h0001);  // end of list
        poke(16'h000F, 16'h0000);
        poke(16'h001F, 16'h0000);
        poke(16'h002F, 16'h0002);  // frame 0x30 is class 2
        poke(16'h0201, 16'h0002);  // class 1 redirects to 0
        poke(16'h0202, 16'h0001);  // class 2 empty
        poke(16'h0203, 16'h0013);  // class 3 -> class 4
        poke(16'h0204, 16'h000A);  // class 4 -> class 2
        poke(16'h0205, 16'h0016);  // class 5 -> itself
        @(negedge clk);
        // R1 reset state
        check(!done && !empty_trap && !loop_err, "R1", "flags in reset",
              {done, empty_trap, loop_err}, 0);
        check(!mem_en, "R1", "mem_en in reset", mem_en, 0);
        check(frame_out == 0, "R1", "frame_out in reset", frame_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && !mem_en, "R1", "idle after reset", {done, mem_en}, 0);

        for (int v = 0; v < NV; v++) begin
            int op, arg, ek, ef, el, ew;
            string t;
            op  = int'(VEC[v][47:46]);
            arg = int'(VEC[v][45:30]);
            ek  = int'(VEC[v][29:28]);
            ef  = int'(VEC[v][27:12]);
            el  = int'(VEC[v][11:4]);
            ew  = int'(VEC[v][3:0]);
            t   = tag_of(op, ek, arg);
            run_op(op, arg[15:0], kind, frm, lat, wrs);
            check(kind == ek, t, $sformatf("vec %0d result kind", v), kind, ek);
            check(int'(frm) == ef, t, $sformatf("vec %0d frame", v), frm, ef);
            check(lat == el, t, $sformatf("vec %0d latency", v), lat, el);
            check(wrs == ew, t, $sformatf("vec %0d writes", v), wrs, ew);
        end

        // R7 LIFO link contents and head updates in memory
        check(mem[10'h020] == 16'h0010, "R7", "link word of 0x20", mem[10'h020], 16'h0010);
        check(mem[10'h030] == 16'h0001, "R7", "link word of 0x30", mem[10'h030], 16'h0001);
        check(mem[10'h200] == 16'h0001, "R2", "class 0 head", mem[10'h200], 16'h0001);

        // R8 simultaneous requests: allocate (class 2, empty) wins, free dropped
        @(negedge clk);
        alloc_req = 1'b1; alloc_class = 8'd2;
        free_req = 1'b1;  free_ptr = 16'h0010;
        @(posedge clk); #1;
        alloc_req = 1'b0; free_req = 1'b0;
        dcount = 0;
        for (int i = 0; i < 12; i++) begin
            if (done) begin
                dcount++;
                check(empty_trap, "R8", "alloc taken over free", empty_trap, 1);
            end
            @(posedge clk); #1;
        end
        check(dcount == 1, "R8", "one completion", dcount, 1);
        check(mem[10'h200] == 16'h0001, "R8", "dropped free left head", mem[10'h200], 16'h0001);

        // R8 request while busy is ignored: free 0x10, pulse alloc mid-flight
        @(negedge clk);
        free_req = 1'b1; free_ptr = 16'h0010;
        @(posedge clk); #1;
        free_req = 1'b0;
        @(negedge clk);
        alloc_req = 1'b1; alloc_class = 8'd0;
        @(posedge clk); #1;
        alloc_req = 1'b0;
        dcount = 0;
        for (int i = 0; i < 12; i++) begin
            if (done) dcount++;
            check(!(mem_en && !done && i > 4), "R10", "no access after finish", mem_en, 0);
            @(posedge clk); #1;
        end
        check(dcount == 1, "R8", "busy request ignored", dcount, 1);
        check(mem[10'h200] == 16'h0010, "R8", "head after free", mem[10'h200], 16'h0010);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule